// File: doc/BRIEF.md
# Multi-Channel Sample Lane Aggregator

The aggregator takes four independent sample lanes and merges them into one wide, sample-aligned output stream. Each lane delivers one 128-bit word per accepted transfer: sixteen 8-bit samples from a single converter channel. A word moves across a lane only when that lane's valid and ready are both high. Each lane has its own 16-word queue, so lanes that start out of step with one another are realigned. A 512-bit output word is issued only when every active lane holds a word. Word k of each active lane therefore leaves in the same output beat, and sample 0 of every channel appears together.

A 4-bit channel-enable input selects the lanes that take part; one, two or four channels are the intended configurations. The applied mask follows the input only while every lane queue is empty. The output honours a ready from downstream. A synchronous flush empties all queues in one cycle. A per-lane sticky flag records any attempt to push into a full queue. Everything runs in a single clock domain.

Top module: `sample_aggregator`

## Requirements
- R1: After reset, out_valid is low, all overflow flags are clear, and every lane_ready is low until the first clock edge after reset loads the applied mask.
- R2: A lane whose bit in the applied mask is 0 keeps lane_ready low, ignores lane_valid and lane_data, never sets its overflow flag, and never affects the output.
- R3: out_valid is high exactly when the applied mask is nonzero, every active lane queue holds a word, and flush is low. On a beat accepted with out_ready high, every active queue pops its oldest word together, so output beat k carries word k of each active lane.
- R4: Lane i occupies out_data bits [128*i+127 : 128*i], with lane 0 in the least significant bits. The slot of an inactive lane is all zeros.
- R5: While out_valid is high and out_ready is low, out_data holds its value and no word is lost.
- R6: Each lane queue holds 16 words. An active lane accepts exactly 16 words while the output is stalled, then drops lane_ready until a pop.
- R7: A lane's overflow flag is set when the lane is active, lane_valid is high, its queue is full and flush is low. The flag stays set until reset and is not cleared by flush.
- R8: A cycle with flush high empties all lane queues. In that cycle lane_ready and out_valid are low and no input word is accepted, so out_valid is low in the following cycle.
- R9: The applied mask takes the value of chan_en at a clock edge only if all lane queues are empty before that edge. Otherwise it keeps its previous value.
- R10: Masks 4'b0001, 4'b0011, 4'b0101 and 4'b1111 each stream correctly aligned data when lanes start with different delays and downstream ready toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous flush of all lane queues |
| chan_en | input | 4 | Requested channel-enable mask, bit i for lane i |
| lane_valid | input | 4 | Per-lane word valid |
| lane_data | input | 4x128 | Per-lane word, sixteen 8-bit samples |
| lane_ready | output | 4 | Per-lane queue can accept |
| out_valid | output | 1 | Aligned output word available |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 512 | Concatenated lane words, lane 0 lowest |
| overflow | output | 4 | Sticky per-lane push-while-full flag |

## Verification
Two functions can fall in the same cycle: a lane pushing a new word and the joined output popping the same queue. Lanes are started with different delays while downstream ready follows a pseudo-random pattern, so push and pop of one queue often share an edge. A scoreboard checks that every output beat matches the words expected at that index, in order and with nothing lost or repeated. A second overlap is flush arriving while a lane is still presenting valid data into a full queue. It is judged by the ready, output-valid and overflow-flag values on each side of the flush cycle.

// File: rtl/sagg_pkg.sv
package sagg_pkg;
    localparam int DEF_LANES    = 4;
    localparam int DEF_SAMPLES  = 16;
    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_DEPTH    = 16;

    // next read/write slot of a circular queue of the given depth
    function automatic int unsigned slot_next(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/sagg_lane_fifo.sv
module sagg_lane_fifo
    import sagg_pkg::*;
#(
    parameter int W     = 128,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic full, push, take;

    assign full     = (st_q.cnt == CW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign in_ready = en & ~full & ~flush;
    assign push     = in_ready & in_valid;
    assign take     = pop & ~empty & ~flush;
    assign head     = mem_q[st_q.rptr];
    assign ovf      = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (push)
                st_d.wptr = AW'(slot_next(int'(st_q.wptr), DEPTH));
            if (take)
                st_d.rptr = AW'(slot_next(int'(st_q.rptr), DEPTH));
            case ({push, take})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
            if (en && in_valid && full)
                st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push)
            mem_q[st_q.wptr] <= in_data;
    end
endmodule

// File: rtl/sagg_join.sv
module sagg_join #(
    parameter int LANES  = 4,
    parameter int LANE_W = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [LANES-1:0]              chan_en,
    input  logic [LANES-1:0]              empty,
    input  logic [LANES-1:0][LANE_W-1:0]  heads,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [LANES*LANE_W-1:0]       out_data,
    output logic [LANES-1:0]              pop,
    output logic [LANES-1:0]              active,
    output logic                          idle
);
    typedef struct packed {
        logic [LANES-1:0] act;
    } join_st_t;

    join_st_t st_d, st_q;
    logic     fire;

    assign idle   = &empty;
    assign active = st_q.act;

    always_comb begin
        st_d = st_q;
        if (idle)
            st_d.act = chan_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = (|st_q.act) & (&(~empty | ~st_q.act)) & ~flush;
    assign fire      = out_valid & out_ready;

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        assign pop[i] = fire & st_q.act[i];
        assign out_data[i*LANE_W +: LANE_W] = st_q.act[i] ? heads[i] : '0;
    end
endmodule

// File: rtl/sample_aggregator.sv
module sample_aggregator
    import sagg_pkg::*;
#(
    parameter int LANES    = DEF_LANES,
    parameter int SAMPLES  = DEF_SAMPLES,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int DEPTH    = DEF_DEPTH,
    localparam int LANE_W  = SAMPLES * SAMPLE_W,
    localparam int OUT_W   = LANES * LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [LANES-1:0]             chan_en,
    input  logic [LANES-1:0]             lane_valid,
    input  logic [LANES-1:0][LANE_W-1:0] lane_data,
    output logic [LANES-1:0]             lane_ready,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [OUT_W-1:0]             out_data,
    output logic [LANES-1:0]             overflow
);
    logic [LANES-1:0]             active_w;
    logic [LANES-1:0]             empty_w;
    logic [LANES-1:0]             pop_w;
    logic [LANES-1:0][LANE_W-1:0] head_w;
    logic                         idle_w;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sagg_lane_fifo #(.W(LANE_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .en       (active_w[i]),
            .in_valid (lane_valid[i]),
            .in_data  (lane_data[i]),
            .in_ready (lane_ready[i]),
            .pop      (pop_w[i]),
            .head     (head_w[i]),
            .empty    (empty_w[i]),
            .ovf      (overflow[i])
        );
    end

    sagg_join #(.LANES(LANES), .LANE_W(LANE_W)) u_join (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .chan_en   (chan_en),
        .empty     (empty_w),
        .heads     (head_w),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .pop       (pop_w),
        .active    (active_w),
        .idle      (idle_w)
    );
endmodule

// File: rtl/sagg_checker.sv
module sagg_checker #(
    parameter int LANES  = 4,
    parameter int LANE_W = 128
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic [LANES-1:0]        lane_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic [LANES-1:0]        overflow,
    input logic [LANES-1:0]        active,
    input logic                    idle
);
    logic [LANES*LANE_W-1:0] slot_keep;
    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign slot_keep[i*LANE_W +: LANE_W] = {LANE_W{active[i]}};
    end

    assert_ready_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ready & ~active) == '0);

    assert_dead_slot_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~slot_keep) == '0));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (flush || (out_valid && $stable(out_data))));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |overflow |=> ((overflow & $past(overflow)) == $past(overflow)));

    assert_flush_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    assert_mask_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active != $past(active)) |-> $past(idle));
endmodule

bind sample_aggregator sagg_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lane_ready (lane_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .overflow   (overflow),
    .active     (active_w),
    .idle       (idle_w)
);

// File: tb/tb_sample_aggregator.sv
module tb_sample_aggregator;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               flush = 1'b0;
    logic [3:0]         chan_en = 4'b0000;
    logic [3:0]         lane_valid = 4'b0000;
    logic [3:0][127:0]  lane_data = '0;
    logic [3:0]         lane_ready;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [511:0]       out_data;
    logic [3:0]         overflow;

    int n_chk = 0;
    int n_bad = 0;
    int rx_count = 0;
    int rdy_mode = 0;          // 0 stall, 1 always, 2 pseudo-random
    logic [7:0] lf = 8'hA5;
    logic done = 1'b0;
    logic [511:0] exp_q [$];

    always #10 clk = ~clk;

    sample_aggregator dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .chan_en(chan_en),
        .lane_valid(lane_valid), .lane_data(lane_data), .lane_ready(lane_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .overflow(overflow)
    );

    function automatic logic [127:0] lane_word(int ln, int k);
        logic [127:0] w;
        for (int s = 0; s < 16; s++)
            w[s*8 +: 8] = 8'(ln * 64 + k * 5 + s * 3 + 1);
        return w;
    endfunction

    function automatic logic [511:0] exp_word(logic [3:0] m, int k);
        logic [511:0] r = '0;
        for (int l = 0; l < 4; l++)
            if (m[l]) r[l*128 +: 128] = lane_word(l, k);
        return r;
    endfunction

    task automatic check(string req, logic [511:0] act, logic [511:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: drives out_ready and scores every accepted beat
    always begin
        @(negedge clk);
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lf[0] : 1'b0;
        #1;
        if (rst_n && out_valid && out_ready) begin
            rx_count++;
            if (exp_q.size() == 0) begin
                check("R3 unexpected beat", out_data, '0);
            end else begin
                check("R3/R4 aligned beat", out_data, exp_q.pop_front());
            end
        end
    end

    task automatic drive_lane(int ln, int n, int dly);
        repeat (dly + 1) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            lane_data[ln]  = lane_word(ln, k);
            lane_valid[ln] = 1'b1;
            #1;
            while (!lane_ready[ln]) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        lane_valid[ln] = 1'b0;
    endtask

    task automatic set_mask(logic [3:0] m);
        @(negedge clk);
        chan_en = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_stream(logic [3:0] m, int n, int skew, int mode, string req);
        set_mask(m);
        rx_count = 0;
        rdy_mode = mode;
        for (int k = 0; k < n; k++) exp_q.push_back(exp_word(m, k));
        for (int l = 0; l < 4; l++) begin
            if (m[l]) begin
                automatic int ll = l;
                fork
                    drive_lane(ll, n, ll * skew);
                join_none
            end
        end
        wait fork;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check({req, " beat count"}, 512'(rx_count), 512'(n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int acc;
        logic [511:0] snap;
        chan_en = 4'b1111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state before the first edge after reset
        check("R1 out_valid", 512'(out_valid), 512'(0));
        check("R1 overflow", 512'(overflow), 512'(0));
        check("R1 lane_ready", 512'(lane_ready), 512'(0));
        @(negedge clk); #1;
        check("R1 ready after mask load", 512'(lane_ready), 512'(4'b1111));

        // R10 / R3 / R4 / R5: streaming under several masks and skews
        run_stream(4'b1111, 12, 3, 2, "R10 mask1111");
        run_stream(4'b0011, 10, 5, 2, "R10 mask0011");
        run_stream(4'b0001, 10, 0, 1, "R10 mask0001");
        run_stream(4'b0101, 8, 2, 2, "R10 mask0101");

        // R9: mask change while data is pending is deferred
        set_mask(4'b0001);
        rdy_mode = 0;
        rx_count = 0;
        exp_q.push_back(exp_word(4'b0001, 0));
        exp_q.push_back(exp_word(4'b0001, 1));
        drive_lane(0, 2, 0);
        chan_en = 4'b0011;
        repeat (2) @(negedge clk);
        #1;
        check("R9 mask held while busy", 512'(lane_ready[1]), 512'(0));
        check("R5 stalled valid", 512'(out_valid), 512'(1));
        snap = out_data;
        check("R5 stalled data", out_data, exp_word(4'b0001, 0));
        @(negedge clk); #1;
        check("R5 data held", out_data, snap);
        rdy_mode = 1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        check("R9 mask applied when idle", 512'(lane_ready[1]), 512'(1));
        check("R9 drained count", 512'(rx_count), 512'(2));

        // R6 / R7 / R2: fill lane 0 with output stalled, lane 3 disabled
        set_mask(4'b0001);
        rdy_mode = 0;
        acc = 0;
        for (int c = 0; c < 20; c++) begin
            lane_data[0]  = lane_word(0, c);
            lane_valid[0] = 1'b1;
            lane_data[3]  = lane_word(3, c);
            lane_valid[3] = 1'b1;
            #1;
            if (lane_ready[0]) acc++;
            @(negedge clk);
        end
        #1;
        check("R6 accepted words", 512'(acc), 512'(16));
        check("R6 ready low when full", 512'(lane_ready[0]), 512'(0));
        check("R7 overflow set", 512'(overflow[0]), 512'(1));
        check("R2 disabled ready", 512'(lane_ready[3]), 512'(0));
        check("R2 disabled no overflow", 512'(overflow[3:1]), 512'(0));
        check("R4 first word, zero slots", out_data, exp_word(4'b0001, 0));

        // R8: flush while lane 0 still presents valid into a full queue
        flush = 1'b1;
        #1;
        check("R8 ready low in flush", 512'(lane_ready[0]), 512'(0));
        check("R8 valid low in flush", 512'(out_valid), 512'(0));
        @(negedge clk);
        flush = 1'b0;
        lane_valid = 4'b0000;
        #1;
        check("R8 empty after flush", 512'(out_valid), 512'(0));
        check("R8 ready after flush", 512'(lane_ready[0]), 512'(1));
        check("R7 sticky across flush", 512'(overflow), 512'(4'b0001));

        repeat (2) @(negedge clk);
        check("R3 no stray beats", 512'(exp_q.size()), 512'(0));
        finish_run();
    end
endmodule